// File: doc/BRIEF.md
# Four-Lane Multi-Format PCM Serial Receiver

This block takes eight channels of PCM audio that arrive on four serial data lines. The lines share one bit clock and one word clock, and each line carries one stereo pair. The block samples the bit clock, the word clock and the four data lines in its own system clock domain. It tracks the slot position inside each half-frame and collects one word per line and per half. When both halves of a frame have arrived complete, it issues a burst of eight samples on a single output port.

Three settings control the receiver:
- the framing: I2S-style delayed, left-justified or right-justified;
- the bit order: most significant bit first or least significant bit first;
- the word width: 16, 18, 20 or 24 bits.

Every sample leaves as a 24-bit two's-complement value. A narrower word sits in the upper bits and the unused low bits are zero. A half-frame that is cut short discards the whole frame, so no half-built pair ever reaches the output.

There are two state machines. The half tracker has the states HALF_SYNC, HALF_LEFT and HALF_RIGHT:
- After reset it sits in HALF_SYNC.
- On each word-clock change it moves to HALF_LEFT or HALF_RIGHT, according to the new word-clock level.
- The frame-done event fires when a HALF_RIGHT ends complete after a complete HALF_LEFT.

The output sequencer has the states EMIT_IDLE and EMIT_SEND:
- EMIT_IDLE moves to EMIT_SEND on frame-done.
- EMIT_SEND stays in EMIT_SEND while it steps through the channel index.
- EMIT_SEND returns to EMIT_IDLE after channel 7.

Top module: `pcm_quad_rx`

## Requirements
- R1: While rst_n is low, and afterwards until a complete frame has been received, smp_valid stays low.
- R2: Data line k (sdata[k]) carries channel 2k in its left half and channel 2k+1 in its right half. smp_chan gives this zero-based channel number (0 to 7).
- R3: With fmt_sel = 2'b00 or 2'b11 (delayed mode), a low word clock marks the left half. The first data bit is sampled one bit-clock period after the word-clock change.
- R4: With fmt_sel = 2'b01 (left-justified), a high word clock marks the left half. The first data bit is sampled on the same bit-clock rising edge that first sees the word-clock change.
- R5: With fmt_sel = 2'b10 (right-justified), a high word clock marks the left half. The word is the last W bits sampled before the next word-clock change.
- R6: With lsb_first = 0 the first bit of a word is its most significant bit. With lsb_first = 1 the first bit is its least significant bit.
- R7: width_sel selects W: 2'b00 gives 16, 2'b01 gives 18, 2'b10 gives 20 and 2'b11 gives 24. The W-bit word goes into smp_data[23:24-W], and the bits below it are zero.
- R8: Each complete frame produces eight samples on eight consecutive clk cycles, with channels in ascending order 0 to 7. Channel 0 appears in the cycle after the fourth rising clk edge that follows the bit-clock rise which ends the right half.
- R9: A frame is dropped entirely, with no output, when either of its halves captured fewer than W bits. A half that did not begin with a word-clock change seen since reset counts as incomplete.
- R10: Bits in slots outside the capture window of the selected framing have no effect on any sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run at least 4 times the bit-clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| lrck | input | 1 | Word clock selecting the left or right half |
| sdata | input | LANES (4) | Serial data lines, one per channel pair |
| fmt_sel | input | 2 | Framing: 00 delayed, 01 left-justified, 10 right-justified, 11 delayed |
| lsb_first | input | 1 | Bit order of the incoming word |
| width_sel | input | 2 | Word width code (16/18/20/24) |
| smp_valid | output | 1 | Sample strobe, high for one clk cycle per sample |
| smp_chan | output | 3 | Channel number of the current sample |
| smp_data | output | 24 | Left-aligned two's-complement sample |

## Verification
The closing bit-clock rise passes through two synchroniser stages, one edge-detect register and the frame-done register. The sequencer enters EMIT_SEND on the fourth clk edge after that rise, and the other seven channels follow one per cycle. The bench stamps the clk cycle in which it raises the closing bit clock and samples outputs on the falling clk edge. Each channel-0 sample must carry a stamp difference of exactly four. Expected samples are queued once the right half has been driven, well before they fall due. Dropped frames are checked after a trailing half plus sixteen idle cycles, by confirming that the received-sample count has not moved.

// File: rtl/pqr_pkg.sv
`timescale 1ns/1ps
package pqr_pkg;

    localparam int SAMPLE_W = 24;
    localparam int WLEN_W   = 5;

    typedef enum logic [1:0] {
        FMT_I2S   = 2'b00,
        FMT_LJ    = 2'b01,
        FMT_RJ    = 2'b10,
        FMT_SPARE = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        HALF_SYNC,
        HALF_LEFT,
        HALF_RIGHT
    } half_e;

    typedef enum logic {
        EMIT_IDLE,
        EMIT_SEND
    } emit_e;

    // Word width in bits for a width code.
    function automatic logic [WLEN_W-1:0] word_bits(input logic [1:0] sel);
        logic [WLEN_W-1:0] n;
        case (sel)
            2'b00:   n = WLEN_W'(16);
            2'b01:   n = WLEN_W'(18);
            2'b10:   n = WLEN_W'(20);
            default: n = WLEN_W'(24);
        endcase
        return n;
    endfunction

    // raw holds the received bits with the newest one at bit 0.
    // Only the low w bits are used; the result is left-aligned.
    function automatic logic [SAMPLE_W-1:0] align_word(
        input logic [SAMPLE_W-1:0] raw,
        input logic [WLEN_W-1:0]   w,
        input logic                lsb
    );
        logic [SAMPLE_W-1:0] r;
        r = '0;
        for (int i = 0; i < SAMPLE_W; i++) begin
            if (i < int'(w)) begin
                int src;
                src = lsb ? (int'(w) - 1 - i) : i;
                r[i + SAMPLE_W - int'(w)] = raw[src];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pqr_sync.sv
`timescale 1ns/1ps
module pqr_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pqr_half_timer.sv
`timescale 1ns/1ps
module pqr_half_timer
    import pqr_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bclk_s,
    input  logic       lrck_s,
    input  logic [1:0] fmt_sel,
    input  logic [1:0] width_sel,
    output logic       tick,
    output logic       half_edge,
    output logic       cap_en,
    output logic       end_left,
    output logic       frame_done
);
    localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

    half_e             state_q, state_d;
    fmt_e              fmt;
    logic              bclk_d, lr_prev, primed, left_ok;
    logic              lr_chg, left_lvl, ok_end;
    logic [SLOT_W-1:0] slot_q, capt_q, cur_slot, wlen;

    // Combinational decode of the current slot.
    always_comb begin
        fmt       = fmt_e'(fmt_sel);
        wlen      = SLOT_W'(word_bits(width_sel));
        left_lvl  = (fmt == FMT_LJ) || (fmt == FMT_RJ);
        tick      = bclk_s & ~bclk_d;
        lr_chg    = primed && (lrck_s != lr_prev);
        half_edge = tick && lr_chg;
        if (lr_chg)
            cur_slot = '0;
        else if (slot_q == SLOT_MAX)
            cur_slot = slot_q;
        else
            cur_slot = slot_q + 1'b1;
        unique case (fmt)
            FMT_LJ:  cap_en = (cur_slot < wlen);
            FMT_RJ:  cap_en = 1'b1;
            default: cap_en = (cur_slot != '0) && (cur_slot <= wlen);
        endcase
        end_left = (state_q == HALF_LEFT);
        ok_end   = (state_q != HALF_SYNC) && (capt_q >= wlen);
    end

    // Next-state logic of the half tracker.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HALF_SYNC, HALF_LEFT, HALF_RIGHT: begin
                if (half_edge)
                    state_d = (lrck_s == left_lvl) ? HALF_LEFT : HALF_RIGHT;
            end
            default: state_d = HALF_SYNC;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= HALF_SYNC;
        else
            state_q <= state_d;
    end

    // Slot and capture bookkeeping plus the frame-done event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_d     <= 1'b0;
            lr_prev    <= 1'b0;
            primed     <= 1'b0;
            left_ok    <= 1'b0;
            slot_q     <= '0;
            capt_q     <= '0;
            frame_done <= 1'b0;
        end else begin
            bclk_d     <= bclk_s;
            frame_done <= half_edge && (state_q == HALF_RIGHT) && left_ok && ok_end;
            if (tick) begin
                primed  <= 1'b1;
                lr_prev <= lrck_s;
                slot_q  <= cur_slot;
                if (half_edge)
                    capt_q <= SLOT_W'(cap_en);
                else if (capt_q != SLOT_MAX)
                    capt_q <= capt_q + SLOT_W'(cap_en);
            end
            if (half_edge)
                left_ok <= end_left ? ok_end : 1'b0;
        end
    end
endmodule

// File: rtl/pqr_lane.sv
`timescale 1ns/1ps
module pqr_lane
    import pqr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                half_edge,
    input  logic                cap_en,
    input  logic                end_left,
    input  logic                bit_in,
    input  logic [1:0]          width_sel,
    input  logic                lsb_first,
    output logic [SAMPLE_W-1:0] left_word,
    output logic [SAMPLE_W-1:0] right_word
);
    logic [SAMPLE_W-1:0] shreg_q;
    logic [SAMPLE_W-1:0] aligned;

    assign aligned = align_word(shreg_q, word_bits(width_sel), lsb_first);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            left_word  <= '0;
            right_word <= '0;
        end else if (tick) begin
            if (half_edge) begin
                if (end_left)
                    left_word <= aligned;
                else
                    right_word <= aligned;
                shreg_q <= cap_en ? SAMPLE_W'(bit_in) : '0;
            end else if (cap_en) begin
                shreg_q <= {shreg_q[SAMPLE_W-2:0], bit_in};
            end
        end
    end
endmodule

// File: rtl/pqr_emit.sv
`timescale 1ns/1ps
module pqr_emit
    import pqr_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int CH_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          frame_done,
    input  logic [NCH-1:0][SAMPLE_W-1:0]  ch_words,
    output logic                          smp_valid,
    output logic [CH_W-1:0]               smp_chan,
    output logic [SAMPLE_W-1:0]           smp_data
);
    localparam logic [CH_W-1:0] LAST = CH_W'(NCH - 1);

    emit_e           state_q, state_d;
    logic [CH_W-1:0] idx_q, idx_d;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            EMIT_IDLE: begin
                if (frame_done) begin
                    state_d = EMIT_SEND;
                    idx_d   = '0;
                end
            end
            EMIT_SEND: begin
                if (idx_q == LAST)
                    state_d = EMIT_IDLE;
                else
                    idx_d = idx_q + 1'b1;
            end
            default: state_d = EMIT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EMIT_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        smp_valid = (state_q == EMIT_SEND);
        smp_chan  = smp_valid ? idx_q : '0;
        smp_data  = smp_valid ? ch_words[idx_q] : '0;
    end
endmodule

// File: rtl/pcm_quad_rx.sv
`timescale 1ns/1ps
module pcm_quad_rx
    import pqr_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int SLOT_W      = 6,
    parameter int SYNC_STAGES = 2,
    parameter int NCH         = 2 * LANES,
    parameter int CH_W        = $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bclk,
    input  logic                 lrck,
    input  logic [LANES-1:0]     sdata,
    input  logic [1:0]           fmt_sel,
    input  logic                 lsb_first,
    input  logic [1:0]           width_sel,
    output logic                 smp_valid,
    output logic [CH_W-1:0]      smp_chan,
    output logic [SAMPLE_W-1:0]  smp_data
);
    localparam int SYNC_W = LANES + 2;

    logic [SYNC_W-1:0]            sync_out;
    logic                         bclk_s, lrck_s;
    logic [LANES-1:0]             sdata_s;
    logic                         tick, half_edge, cap_en, end_left, frame_done;
    logic [NCH-1:0][SAMPLE_W-1:0] ch_words;

    pqr_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sdata, lrck, bclk}),
        .dout (sync_out)
    );

    assign bclk_s  = sync_out[0];
    assign lrck_s  = sync_out[1];
    assign sdata_s = sync_out[SYNC_W-1:2];

    pqr_half_timer #(.SLOT_W(SLOT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_s    (bclk_s),
        .lrck_s    (lrck_s),
        .fmt_sel   (fmt_sel),
        .width_sel (width_sel),
        .tick      (tick),
        .half_edge (half_edge),
        .cap_en    (cap_en),
        .end_left  (end_left),
        .frame_done(frame_done)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pqr_lane u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .half_edge (half_edge),
            .cap_en    (cap_en),
            .end_left  (end_left),
            .bit_in    (sdata_s[g]),
            .width_sel (width_sel),
            .lsb_first (lsb_first),
            .left_word (ch_words[2*g]),
            .right_word(ch_words[2*g+1])
        );
    end

    pqr_emit #(.NCH(NCH), .CH_W(CH_W)) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_done(frame_done),
        .ch_words  (ch_words),
        .smp_valid (smp_valid),
        .smp_chan  (smp_chan),
        .smp_data  (smp_data)
    );
endmodule

// File: rtl/pcm_quad_rx_chk.sv
`timescale 1ns/1ps
module pcm_quad_rx_chk #(
    parameter int NCH    = 8,
    parameter int CH_W   = 3,
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic [CH_W-1:0]   smp_chan,
    input logic [DATA_W-1:0] smp_data,
    input logic [1:0]        width_sel
);
    localparam logic [CH_W-1:0] LAST = CH_W'(NCH - 1);

    logic [DATA_W-1:0] low_mask;

    always_comb begin
        case (width_sel)
            2'b00:   low_mask = DATA_W'(8'hFF);
            2'b01:   low_mask = DATA_W'(8'h3F);
            2'b10:   low_mask = DATA_W'(8'h0F);
            default: low_mask = '0;
        endcase
    end

    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !smp_valid);

    // R8
    burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smp_valid) |-> (smp_chan == '0));

    // R8
    chan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_chan != LAST) |=> (smp_valid && smp_chan == $past(smp_chan) + 1'b1));

    // R8
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_chan == LAST) |=> !smp_valid);

    // R7
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> ((smp_data & low_mask) == '0));
endmodule

bind pcm_quad_rx pcm_quad_rx_chk #(
    .NCH   (NCH),
    .CH_W  (CH_W),
    .DATA_W(pqr_pkg::SAMPLE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .smp_chan (smp_chan),
    .smp_data (smp_data),
    .width_sel(width_sel)
);

// File: tb/sim_pcm_quad_rx.sv
`timescale 1ns/1ps
module sim_pcm_quad_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        lrck = 1'b0;
    logic [3:0]  sdata = '0;
    logic [1:0]  fmt_sel = '0;
    logic        lsb_first = 1'b0;
    logic [1:0]  width_sel = '0;
    logic        smp_valid;
    logic [2:0]  smp_chan;
    logic [23:0] smp_data;

    int unsigned cyc = 0;
    int unsigned close_cyc = 0;
    int          checks = 0;
    int          errors = 0;
    int          recv_cnt = 0;
    bit          done = 1'b0;
    string       cur_tag = "R3";
    logic [26:0] exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pcm_quad_rx u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .lrck     (lrck),
        .sdata    (sdata),
        .fmt_sel  (fmt_sel),
        .lsb_first(lsb_first),
        .width_sel(width_sel),
        .smp_valid(smp_valid),
        .smp_chan (smp_chan),
        .smp_data (smp_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int width_of(input int ws);
        case (ws)
            0: return 16;
            1: return 18;
            2: return 20;
            default: return 24;
        endcase
    endfunction

    function automatic logic [23:0] expect_val(input logic [23:0] word, input int w);
        logic [23:0] m;
        m = 24'((32'd1 << w) - 1);
        return (word & m) << (24 - w);
    endfunction

    // Position of slot s inside the word window, -1 or >= w when outside.
    function automatic int pos_in(input int f, input int s, input int len, input int w);
        case (f)
            0: return s - 1;
            1: return s;
            default: return s - (len - w);
        endcase
    endfunction

    // Monitor: compares every strobed sample with the expected queue.
    always @(negedge clk) begin
        if (rst_n && smp_valid) begin
            logic [26:0] e;
            recv_cnt++;
            if (smp_chan == 3'd0)
                chk((cyc - close_cyc) == 4, "R8 burst latency", cyc - close_cyc, 4);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 sample from a dropped frame", {smp_chan, smp_data}, 0);
            end else begin
                e = exp_q.pop_front();
                chk(smp_chan == e[26:24], "R2 channel order", smp_chan, e[26:24]);
                chk(smp_data == e[23:0], {cur_tag, " R7 R10 sample value"}, smp_data, e[23:0]);
            end
        end
    end

    task automatic drive_slot(input logic lv, input logic [3:0] bits, input bit first);
        @(negedge clk);
        bclk  = 1'b0;
        lrck  = lv;
        sdata = bits;
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        if (first) close_cyc = cyc;
    endtask

    task automatic drive_half(input logic lv, input int len, input int f, input bit lsb,
                              input int w, input logic [3:0][23:0] wd);
        for (int s = 0; s < len; s++) begin
            logic [3:0] b;
            int p;
            p = pos_in(f, s, len, w);
            for (int k = 0; k < 4; k++) begin
                if (p >= 0 && p < w)
                    b[k] = wd[k][lsb ? p : (w - 1 - p)];
                else
                    b[k] = 1'($urandom % 2);
            end
            drive_slot(lv, b, s == 0);
        end
    endtask

    task automatic run_frame(input int f, input bit lsb, input int w, input int lenl,
                             input int lenr, input int pat, input bit push);
        logic [3:0][23:0] wl, wr;
        logic lvl;
        lvl = (f == 0) ? 1'b0 : 1'b1;
        for (int k = 0; k < 4; k++) begin
            if (pat == 1) begin
                wl[k] = '1;
                wr[k] = 24'(32'd1 << (w - 1));
            end else begin
                wl[k] = 24'($urandom);
                wr[k] = 24'($urandom);
            end
        end
        drive_half(lvl, lenl, f, lsb, w, wl);
        drive_half(~lvl, lenr, f, lsb, w, wr);
        if (push) begin
            for (int k = 0; k < 4; k++) begin
                exp_q.push_back({3'(2 * k), expect_val(wl[k], w)});
                exp_q.push_back({3'(2 * k + 1), expect_val(wr[k], w)});
            end
        end
    endtask

    task automatic lead_in(input int f);
        logic [3:0][23:0] junk;
        junk = {4{24'($urandom)}};
        drive_half((f == 0) ? 1'b1 : 1'b0, 32, f, 1'b0, 24, junk);
    endtask

    task automatic trailer(input int f);
        logic [3:0][23:0] junk;
        junk = {4{24'($urandom)}};
        drive_half((f == 0) ? 1'b0 : 1'b1, 2, f, 1'b0, 24, junk);
    endtask

    task automatic set_cfg(input int f, input bit l, input int ws);
        @(negedge clk);
        fmt_sel   = 2'(f);
        lsb_first = l;
        width_sel = 2'(ws);
        cur_tag   = (f == 0) ? "R3" : (f == 1) ? "R4" : "R5";
        if (l) cur_tag = {cur_tag, " R6"};
    endtask

    task automatic drop_case(input int f, input int ws, input int lenl, input int lenr);
        int rc0;
        int w;
        w = width_of(ws);
        set_cfg(f, 1'b0, ws);
        rc0 = recv_cnt;
        lead_in(f);
        run_frame(f, 1'b0, w, lenl, lenr, 0, 1'b0);
        trailer(f);
        repeat (16) @(negedge clk);
        chk(recv_cnt == rc0, "R9 short half drops the frame", recv_cnt - rc0, 0);
        lead_in(f);
        run_frame(f, 1'b0, w, 32, 32, 0, 1'b1);
        trailer(f);
        repeat (16) @(negedge clk);
        chk(exp_q.size() == 0, "R9 recovery after drop", exp_q.size(), 0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd5150);
        rst_n = 1'b0;
        repeat (10) @(negedge clk);
        chk(smp_valid == 1'b0, "R1 idle during reset", smp_valid, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(smp_valid == 1'b0, "R1 idle after reset", smp_valid, 0);

        for (int f = 0; f < 3; f++) begin
            for (int l = 0; l < 2; l++) begin
                for (int ws = 0; ws < 4; ws++) begin
                    int w;
                    w = width_of(ws);
                    set_cfg(f, l[0], ws);
                    lead_in(f);
                    run_frame(f, l[0], w, 32, 32, 1, 1'b1);
                    run_frame(f, l[0], w, 25 + int'($urandom % 8), 25 + int'($urandom % 8), 0, 1'b1);
                    trailer(f);
                    repeat (16) @(negedge clk);
                    chk(exp_q.size() == 0, "R2 all eight channels delivered", exp_q.size(), 0);
                end
            end
        end

        // R9: short left half, left-justified 16 bits
        drop_case(1, 0, 10, 32);
        // R9: short right half, delayed mode 24 bits
        drop_case(0, 3, 32, 20);
        // R9: short left half, right-justified 20 bits
        drop_case(2, 2, 18, 32);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R8 actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule